// File: doc/BRIEF.md
# Pipelined Segment Trie Matcher

This block scans a byte stream for a set of short pattern segments. The segments are stored as a character tree that has only forward edges: every transition goes from a node at depth d to a node at depth d+1. The tree is split over K pipeline stages, with K = 4 by default. Stage 1 holds the children of the root. It is a 256-entry table indexed directly by the folded input byte. Each deeper stage holds FANOUT parallel ways. All children of one node sit at the same address across those ways.

A new thread starts at every accepted byte. On each accepted byte, every live thread advances one level, and all stages compare their ways against the current byte at the same time. A thread that finds no matching way dies. A thread that reaches an entry marked end-of-segment emits an event. The event carries the segment ID, the stream position of the last byte and a flag that says whether the segment is a whole pattern. Short patterns are therefore reported directly. Segments of longer patterns are flagged for a downstream combiner.

Input letters are folded to lower case before lookup. Entries can also demand a particular letter case for their character. Events go into a small FIFO and leave it one per cycle. Tables are written one entry per cycle through a load port, and matching pauses while the port is in use.

Top module: `seg_trie_matcher`

## Requirements
- R1: After reset, ev_valid is 0, in_ready is 1 and every table entry is invalid, so no byte produces an event.
- R2: Input bytes 'A'..'Z' are folded to 'a'..'z' before comparison, so an upper-case input matches a lower-case stored symbol.
- R3: The stage-1 table is indexed by the folded byte, and its entry at that index starts a thread when its valid bit is set.
- R4: A deeper stage searches all FANOUT ways at the address named by the previous entry's next-state field, and any way may hold the matching child.
- R5: A thread starts at every accepted byte. Overlapping occurrences are each reported; for example, pattern "zz" on input "zzz" reports positions 1 and 2.
- R6: A thread whose byte matches no valid way at its stage is dropped and reports nothing afterwards.
- R7: An event gives the segment ID, the end position and a full-pattern flag. The end position is the 0-based count of bytes accepted since reset. The event first appears in the cycle after the last byte is accepted.
- R8: When several threads end on the same byte, their events leave on consecutive cycles, the longest (earliest-started) thread first.
- R9: An entry whose case-check bit is set lets a thread report later only if the input byte's upper-case state equals the entry's upper bit. The upper-case state is true for 'A'..'Z'.
- R10: While ld_en is 1, in_ready is 0, input bytes are ignored and do not advance the stream position, and ld_data is written to table ld_stage (0 = root table, indexed by ld_addr), address ld_addr and way ld_way.
- R11: Cycles with in_valid low do not advance threads, so matching continues across gaps.
- R12: A segment of exactly K characters is reported at the last stage.
- R13: Entry layout of ld_data: bit 0 valid, bits 8:1 symbol (lower case), bit 9 end-of-segment, bit 10 full pattern, bit 11 case-check, bit 12 upper, next 4 bits next-state address, top 6 bits segment ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is present |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Byte will be accepted this cycle |
| ld_en | input | 1 | Write one table entry; stalls matching |
| ld_stage | input | 2 | Target stage, 0 = root table |
| ld_addr | input | 8 | Entry address (byte for root) |
| ld_way | input | 1 | Way within a deeper stage |
| ld_data | input | 23 | Entry contents (layout in R13) |
| ev_valid | output | 1 | Event at FIFO head |
| ev_seg | output | 6 | Segment ID of the event |
| ev_pos | output | 16 | End position of the event |
| ev_full | output | 1 | Segment is a whole pattern |

## Verification
A bad next-state address or a lost thread flag appears as a missing or extra event. The event appears or goes missing within K accepted bytes of the fault, because no thread lives longer than that. A bad position counter shows on the next event's ev_pos. A FIFO pointer fault shows as swapped or repeated segment IDs in the cycles right after a multi-event byte. The bench drives a stream whose overlaps, kills, case failures and same-byte endings are each worked out by hand, and it compares every event field.

// File: rtl/seg_trie_matcher.sv
module seg_trie_matcher #(
  parameter int K          = 4,
  parameter int FANOUT     = 2,
  parameter int NODES      = 16,
  parameter int SEGW       = 6,
  parameter int POSW       = 16,
  parameter int FD         = 8,
  parameter bit CASE_CHECK = 1'b1,
  localparam int NW  = $clog2(NODES),
  localparam int WW  = (FANOUT > 1) ? $clog2(FANOUT) : 1,
  localparam int SW  = (K > 1) ? $clog2(K) : 1,
  localparam int EW  = 13 + NW + SEGW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  output logic            in_ready,
  input  logic            ld_en,
  input  logic [SW-1:0]   ld_stage,
  input  logic [7:0]      ld_addr,
  input  logic [WW-1:0]   ld_way,
  input  logic [EW-1:0]   ld_data,
  output logic            ev_valid,
  output logic [SEGW-1:0] ev_seg,
  output logic [POSW-1:0] ev_pos,
  output logic            ev_full
);
  localparam int F_V    = 0;
  localparam int F_SYM  = 1;
  localparam int F_END  = 9;
  localparam int F_FULL = 10;
  localparam int F_CS   = 11;
  localparam int F_UP   = 12;
  localparam int F_NXT  = 13;
  localparam int F_SEG  = 13 + NW;
  localparam int FDW    = $clog2(FD);
  localparam int CW     = $clog2(FD + 1);
  localparam int QW     = SEGW + POSW + 1;

  logic [EW-1:0] root_mem [256];
  logic [EW-1:0] deep_mem [K-1][NODES][FANOUT];

  logic [K-2:0]  tv, tc;
  logic [NW-1:0] ta [K-1];
  logic [POSW-1:0] pos;

  logic [QW-1:0]  fifo [FD];
  logic [FDW-1:0] wr, rd;
  logic [CW-1:0]  cnt;

  logic [7:0] byte_l;
  logic       byte_up, accept, pop;
  logic [EW-1:0] hent [K];
  logic [K-1:0]  hit, cok, evb;
  logic [FDW-1:0] off [K];
  logic [CW-1:0]  npush;

  assign byte_up  = (in_byte >= 8'h41) && (in_byte <= 8'h5A);
  assign byte_l   = byte_up ? (in_byte | 8'h20) : in_byte;
  assign in_ready = !ld_en && (cnt <= CW'(FD - K));
  assign accept   = in_valid && in_ready;
  assign pop      = (cnt != '0);

  always_comb begin
    for (int j = 0; j < K; j++) begin
      hent[j] = '0;
      hit[j]  = 1'b0;
    end
    hent[0] = root_mem[byte_l];
    hit[0]  = hent[0][F_V] && (hent[0][F_SYM +: 8] == byte_l);
    for (int j = 1; j < K; j++)
      for (int w = 0; w < FANOUT; w++)
        if (tv[j-1] && !hit[j] && deep_mem[j-1][ta[j-1]][w][F_V] &&
            deep_mem[j-1][ta[j-1]][w][F_SYM +: 8] == byte_l) begin
          hit[j]  = 1'b1;
          hent[j] = deep_mem[j-1][ta[j-1]][w];
        end
  end

  always_comb begin
    for (int j = 0; j < K; j++) begin
      cok[j] = !CASE_CHECK || !hent[j][F_CS] || (hent[j][F_UP] == byte_up);
      if (j > 0) cok[j] = cok[j] && tc[(j > 0) ? j-1 : 0];
      evb[j] = hit[j] && hent[j][F_END] && cok[j];
    end
  end

  always_comb begin
    npush = '0;
    for (int j = K - 1; j >= 0; j--) begin
      off[j] = FDW'(npush);
      npush  = npush + CW'(evb[j]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) root_mem[i] <= '0;
      for (int s = 0; s < K - 1; s++)
        for (int a = 0; a < NODES; a++)
          for (int w = 0; w < FANOUT; w++) deep_mem[s][a][w] <= '0;
    end else if (ld_en) begin
      if (ld_stage == '0) root_mem[ld_addr] <= ld_data;
      else deep_mem[ld_stage - SW'(1)][ld_addr[NW-1:0]][ld_way] <= ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv  <= '0;
      tc  <= '0;
      pos <= '0;
      for (int j = 0; j < K - 1; j++) ta[j] <= '0;
    end else if (accept) begin
      for (int j = 0; j < K - 1; j++) begin
        tv[j] <= hit[j];
        tc[j] <= cok[j];
        ta[j] <= hent[j][F_NXT +: NW];
      end
      pos <= pos + POSW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (accept)
      for (int j = 0; j < K; j++)
        if (evb[j])
          fifo[wr + off[j]] <= {hent[j][F_SEG +: SEGW], pos, hent[j][F_FULL]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr  <= '0;
      rd  <= '0;
      cnt <= '0;
    end else begin
      if (accept) wr <= wr + FDW'(npush);
      if (pop) rd <= rd + FDW'(1);
      cnt <= cnt + (accept ? npush : CW'(0)) - CW'(pop);
    end
  end

  assign ev_valid = pop;
  assign {ev_seg, ev_pos, ev_full} = fifo[rd];

  a_r8_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FD));

  a_r7_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pos == $past(pos) + POSW'(1));

  a_r10_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (pos == $past(pos)) && (tv == $past(tv)));

  for (genvar j = 1; j < K - 1; j++) begin : g_chain
    a_r5_thread_chain: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!tv[j] || $past(tv[j-1])));
  end
endmodule

// File: tb/test_seg_trie_matcher.sv
module test_seg_trie_matcher;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, ld_en = 1'b0;
  logic [7:0] in_byte = '0, ld_addr = '0;
  logic [1:0] ld_stage = '0;
  logic ld_way = 1'b0;
  logic [22:0] ld_data = '0;
  logic in_ready, ev_valid, ev_full;
  logic [5:0] ev_seg;
  logic [15:0] ev_pos;

  seg_trie_matcher i_seg_trie_matcher (.*);

  always #4 clk = ~clk;

  int total = 0, fails = 0, nlog = 0;
  logic [5:0]  lseg [64];
  logic [15:0] lpos [64];
  logic        lfull [64];

  always @(negedge clk)
    if (rst_n && ev_valid && nlog < 64) begin
      lseg[nlog] = ev_seg; lpos[nlog] = ev_pos; lfull[nlog] = ev_full;
      nlog++;
    end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [22:0] mk(input logic [7:0] sym, input logic [3:0] nxt,
      input bit endf, input bit full, input bit cs, input bit up, input logic [5:0] seg);
    return {seg, nxt, up, cs, full, endf, sym, 1'b1};
  endfunction

  task automatic load(input logic [1:0] st, input logic [7:0] a, input bit w, input logic [22:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_stage = st; ld_addr = a; ld_way = w; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  typedef struct packed {
    logic [7:0] b; logic [1:0] n; logic [5:0] s0; logic [15:0] p0; logic f0; logic [5:0] s1;
  } vec_t;

  localparam vec_t VT [21] = '{
    '{"a", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"p", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"p", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"l", 2'd2, 6'd5, 16'd3, 1'b0, 6'd8},   // R8 R12: "appl" then "pl"
    '{"P", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"a", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"t", 2'd1, 6'd3, 16'd6, 1'b1, 6'd0},   // R2: "Pat" matches "pat"
    '{"z", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"z", 2'd1, 6'd7, 16'd8, 1'b1, 6'd0},   // R5
    '{"z", 2'd1, 6'd7, 16'd9, 1'b1, 6'd0},   // R5 overlap
    '{"p", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"a", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"x", 2'd1, 6'd9, 16'd12, 1'b1, 6'd0},  // R6 "pax" dies, R3 "x" root
    '{"b", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"B", 2'd1, 6'd12, 16'd14, 1'b1, 6'd0}, // R9 case agrees
    '{"b", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},   // R9 case disagrees
    '{"b", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"p", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"a", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"s", 2'd0, 6'd0, 16'd0, 1'b0, 6'd0},
    '{"t", 2'd1, 6'd4, 16'd20, 1'b1, 6'd0}   // R4 way 1, R12 "past"
  };

  initial begin
    #(8 * 200000);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    check(ev_valid == 1'b0, "R1 ev_valid after reset", int'(ev_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    nlog = 0;
    send("x"); repeat (6) @(negedge clk);
    check(nlog == 0, "R1 empty tables give no event", nlog, 0);
    do_reset();

    // R13 layout used by mk
    load(0, "a", 0, mk("a", 1, 0, 0, 0, 0, 0));
    load(0, "p", 0, mk("p", 2, 0, 0, 0, 0, 0));
    load(0, "x", 0, mk("x", 0, 1, 1, 0, 0, 9));
    load(0, "b", 0, mk("b", 3, 0, 0, 0, 0, 0));
    load(0, "z", 0, mk("z", 4, 0, 0, 0, 0, 0));
    load(1, 1, 0, mk("p", 1, 0, 0, 0, 0, 0));
    load(1, 1, 1, mk("m", 2, 0, 0, 0, 0, 0));
    load(1, 2, 0, mk("a", 3, 0, 0, 0, 0, 0));
    load(1, 2, 1, mk("l", 0, 1, 1, 0, 0, 8));
    load(1, 3, 0, mk("b", 0, 1, 1, 1, 1, 12));
    load(1, 4, 0, mk("z", 0, 1, 1, 0, 0, 7));
    load(2, 1, 0, mk("p", 1, 0, 0, 0, 0, 0));
    load(2, 2, 0, mk("p", 2, 0, 0, 0, 0, 0));
    load(2, 3, 0, mk("t", 0, 1, 1, 0, 0, 3));
    load(2, 3, 1, mk("s", 3, 0, 0, 0, 0, 0));
    load(3, 1, 0, mk("l", 0, 1, 0, 0, 0, 5));
    load(3, 2, 0, mk("l", 0, 1, 0, 0, 0, 6));
    load(3, 3, 0, mk("t", 0, 1, 1, 0, 0, 4));

    foreach (VT[i]) begin
      nlog = 0;
      send(VT[i].b);
      repeat (6) @(negedge clk);
      check(nlog == int'(VT[i].n), $sformatf("R5 R6 event count at byte %0d", i), nlog, int'(VT[i].n));
      if (VT[i].n != 0 && nlog >= 1) begin
        check(lseg[0] == VT[i].s0, "R7 segment id", int'(lseg[0]), int'(VT[i].s0));
        check(lpos[0] == VT[i].p0, "R7 end position", int'(lpos[0]), int'(VT[i].p0));
        check(lfull[0] == VT[i].f0, "R7 full flag", int'(lfull[0]), int'(VT[i].f0));
      end
      if (VT[i].n == 2 && nlog >= 2) begin
        check(lseg[1] == VT[i].s1, "R8 second event order", int'(lseg[1]), int'(VT[i].s1));
        check(lpos[1] == VT[i].p0, "R8 second event position", int'(lpos[1]), int'(VT[i].p0));
      end
    end

    // R10: byte during load is ignored, entry is written
    nlog = 0;
    @(negedge clk);
    ld_en = 1'b1; ld_stage = 0; ld_addr = "q"; ld_way = 0; ld_data = mk("q", 0, 1, 1, 0, 0, 20);
    in_valid = 1'b1; in_byte = "x";
    #1 check(in_ready == 1'b0, "R10 in_ready low while loading", int'(in_ready), 0);
    @(negedge clk);
    ld_en = 1'b0; in_valid = 1'b0;
    repeat (6) @(negedge clk);
    check(nlog == 0, "R10 byte during load ignored", nlog, 0);
    send("q"); repeat (6) @(negedge clk);
    check(nlog == 1, "R10 loaded entry matches", nlog, 1);
    check(lseg[0] == 6'd20, "R10 loaded segment id", int'(lseg[0]), 20);
    check(lpos[0] == 16'd21, "R10 position not advanced by ignored byte", int'(lpos[0]), 21);

    // R11: gap between bytes keeps the thread alive
    nlog = 0;
    send("z"); repeat (10) @(negedge clk);
    send("z"); repeat (6) @(negedge clk);
    check(nlog == 1, "R11 match across idle gap", nlog, 1);
    check(lpos[0] == 16'd23, "R11 position after gap", int'(lpos[0]), 23);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule